// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block produces the array address for a synchronous burst SRAM. A burst starts when either of two active-low address strobes is sampled low on a rising clock edge: one strobe comes from the processor and one from the memory controller. At that edge the external address is loaded. After the load, the following addresses come from an internal beat counter. The counter moves forward once for every edge at which the active-low advance input is low. Between steps the address is held, which suspends the burst.

Only the lowest address bits take part in a burst. With the default setting of two burst bits, a burst is four beats long. It wraps inside its aligned group of four, and the upper address bits never change until the next load. A mode pin picks the order of the beats, either interleaved or linear. The mode is captured only at a load, so the order stays fixed for the rest of that burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and after its release until the first load or step, addr_o is all zeros.
- R2: A rising edge with strb_proc_ni low loads addr_i, and addr_o shows it after that edge. This holds whatever the levels of strb_ctrl_ni and adv_ni, so the processor strobe wins when both strobes are low.
- R3: A rising edge with strb_ctrl_ni low and strb_proc_ni high also loads addr_i into addr_o, whatever the level of adv_ni.
- R4: When order_lin_i was 0 at the last load, beat k of the burst (k = 0..3, where the load itself is beat 0) has addr_o[1:0] equal to the start bits XOR k.
- R5: When order_lin_i was 1 at the last load, beat k has addr_o[1:0] equal to the start bits plus k, modulo 4.
- R6: An edge with both strobes high and adv_ni low steps the burst by one beat. The upper bits addr_o[ADDR_W-1:2] do not change, addr_i is ignored, and after four steps addr_o is back at the start address.
- R7: An edge with both strobes high and adv_ni high leaves addr_o unchanged.
- R8: A change of order_lin_i between loads has no effect on the order of the burst already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External start address |
| strb_proc_ni | input | 1 | Processor address strobe, active low, highest priority |
| strb_ctrl_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_lin_i | input | 1 | Burst order: 1 selects linear, 0 selects interleaved |
| addr_o | output | ADDR_W | Current array address |

## Verification
The assertions check four things on every cycle. A strobe edge makes the next addr_o equal to the sampled addr_i. A hold edge leaves addr_o stable. The upper bits stay fixed across any edge without a strobe. A step moves the low bits by one in linear order and changes them in interleaved order, with the order taken from a shadow copy of the mode captured at each load. The exact interleaved beat sequence, the return to the start address after four beats, and the fact that the mode is ignored in the middle of a burst are shown only by the bench. The bench sweeps every start address, both orders and all three strobe combinations in a narrow configuration. During each burst it toggles the mode and drives junk on the address input.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_STEP = 2'd2
  } seq_cmd_e;

  typedef enum logic {
    ORD_INTLV  = 1'b0,
    ORD_LINEAR = 1'b1
  } burst_ord_e;
endpackage

// File: rtl/burst_strobe_dec.sv
module burst_strobe_dec
  import burst_seq_pkg::*;
(
  input  logic     strb_proc_ni,
  input  logic     strb_ctrl_ni,
  input  logic     adv_ni,
  output seq_cmd_e cmd_o
);
  logic proc_hit;
  logic ctrl_hit;

  assign proc_hit = ~strb_proc_ni;
  assign ctrl_hit = strb_proc_ni & ~strb_ctrl_ni;

  always_comb begin
    cmd_o = CMD_HOLD;
    if (proc_hit)     cmd_o = CMD_LOAD;
    else if (ctrl_hit) cmd_o = CMD_LOAD;
    else if (!adv_ni) cmd_o = CMD_STEP;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
#(
  parameter int unsigned BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  seq_cmd_e           cmd_i,
  input  logic [BURST_W-1:0] start_i,
  input  burst_ord_e         ord_i,
  output logic [BURST_W-1:0] start_o,
  output logic [BURST_W-1:0] beat_o,
  output burst_ord_e         ord_o
);
  logic [BURST_W-1:0] start_q, beat_q;
  burst_ord_e         ord_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      beat_q  <= '0;
      ord_q   <= ORD_INTLV;
    end else begin
      unique case (cmd_i)
        CMD_LOAD: begin
          start_q <= start_i;
          beat_q  <= '0;
          ord_q   <= ord_i;  // order frozen until next load
        end
        CMD_STEP: beat_q <= beat_q + 1'b1;  // natural wrap inside burst
        default:  ;
      endcase
    end
  end

  assign start_o = start_q;
  assign beat_o  = beat_q;
  assign ord_o   = ord_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned BURST_W = 2
) (
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] beat_i,
  input  burst_ord_e         ord_i,
  output logic [BURST_W-1:0] lo_o
);
  logic [BURST_W-1:0] intlv_lo;
  logic [BURST_W-1:0] lin_lo;

  for (genvar b = 0; b < BURST_W; b++) begin : g_intlv
    assign intlv_lo[b] = start_i[b] ^ beat_i[b];
  end

  assign lin_lo = start_i + beat_i;  // modulo 2**BURST_W
  assign lo_o   = (ord_i == ORD_LINEAR) ? lin_lo : intlv_lo;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strb_proc_ni,
  input  logic              strb_ctrl_ni,
  input  logic              adv_ni,
  input  logic              order_lin_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  seq_cmd_e           cmd;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] start_bits, beat, lo_bits;
  burst_ord_e         ord_cur;
  burst_ord_e         ord_in;

  assign ord_in = order_lin_i ? ORD_LINEAR : ORD_INTLV;

  burst_strobe_dec u_dec (
    .strb_proc_ni (strb_proc_ni),
    .strb_ctrl_ni (strb_ctrl_ni),
    .adv_ni       (adv_ni),
    .cmd_o        (cmd)
  );

  burst_beat_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .start_i (addr_i[BURST_W-1:0]),
    .ord_i   (ord_in),
    .start_o (start_bits),
    .beat_o  (beat),
    .ord_o   (ord_cur)
  );

  burst_order_map #(.BURST_W(BURST_W)) u_map (
    .start_i (start_bits),
    .beat_i  (beat),
    .ord_i   (ord_cur),
    .lo_o    (lo_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hi_q <= '0;
    else if (cmd == CMD_LOAD)  hi_q <= addr_i[ADDR_W-1:BURST_W];
  end

  assign addr_o = {hi_q, lo_bits};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned BURST_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              strb_proc_ni,
  input logic              strb_ctrl_ni,
  input logic              adv_ni,
  input logic              order_lin_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic load_e, step_e, hold_e, lin_seen;

  assign load_e = ~strb_proc_ni | ~strb_ctrl_ni;
  assign step_e = strb_proc_ni & strb_ctrl_ni & ~adv_ni;
  assign hold_e = strb_proc_ni & strb_ctrl_ni & adv_ni;

  // shadow of the order captured at each load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lin_seen <= 1'b0;
    else if (load_e) lin_seen <= order_lin_i;
  end

  AST_PROC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_proc_ni |=> addr_o == $past(addr_i)); // R2

  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_proc_ni && !strb_ctrl_ni) |=> addr_o == $past(addr_i)); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_e |=> $stable(addr_o)); // R7

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_e |=> $stable(addr_o[ADDR_W-1:BURST_W])); // R6

  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_e && lin_seen) |=>
      addr_o[BURST_W-1:0] == BURST_W'($past(addr_o[BURST_W-1:0]) + 1'b1)); // R5

  AST_INTLV_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_e && !lin_seen) |=>
      $countones(addr_o[BURST_W-1:0] ^ $past(addr_o[BURST_W-1:0])) != 0); // R4

  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (addr_o == '0); // R1
  end
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .strb_proc_ni (strb_proc_ni),
  .strb_ctrl_ni (strb_ctrl_ni),
  .adv_ni       (adv_ni),
  .order_lin_i  (order_lin_i),
  .addr_o       (addr_o)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 6;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          strb_proc_ni = 1'b1;
  logic          strb_ctrl_ni = 1'b1;
  logic          adv_ni = 1'b1;
  logic          order_lin_i = 1'b0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  burst_addr_seq #(.ADDR_W(AW), .BURST_W(2)) u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .strb_proc_ni (strb_proc_ni),
    .strb_ctrl_ni (strb_ctrl_ni),
    .adv_ni       (adv_ni),
    .order_lin_i  (order_lin_i),
    .addr_o       (addr_o)
  );

  task automatic cyc(input logic [AW-1:0] a, input logic p, input logic c,
                     input logic adv, input logic lin);
    @(negedge clk_i);
    addr_i = a; strb_proc_ni = p; strb_ctrl_ni = c; adv_ni = adv; order_lin_i = lin;
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input logic [AW-1:0] exp, input string req);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL %s addr_o=%h expected=%h", req, addr_o, exp);
    end
  endtask

  function automatic logic [1:0] beat_lo(input logic [1:0] s, input int k, input bit lin);
    return lin ? 2'((int'(s) + k) % 4) : (s ^ 2'(k));
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2;
    chk('0, "R1 in reset");
    repeat (2) @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    cyc(6'h2d, 1'b1, 1'b1, 1'b1, 1'b0);
    chk('0, "R1 after release");

    for (int a = 0; a < (1 << AW); a++) begin
      for (int lin = 0; lin < 2; lin++) begin
        for (int s = 0; s < 3; s++) begin
          logic [AW-1:0] st;
          logic [AW-1:0] cur;
          st = AW'(a);
          // s: 0 proc only, 1 ctrl only, 2 both low; advance level arbitrary
          cyc(st, s == 1, s == 0, a[0], lin[0]);
          if (s == 1) chk(st, "R3 ctrl load");
          else        chk(st, "R2 proc load");
          for (int k = 1; k <= 4; k++) begin
            // toggled mode and junk address must not matter mid-burst
            cyc(~st, 1'b1, 1'b1, 1'b0, ~lin[0]);
            cur = {st[AW-1:2], beat_lo(st[1:0], k % 4, lin[0])};
            if (lin != 0) chk(cur, "R5 R6 R8 linear step");
            else          chk(cur, "R4 R6 R8 interleaved step");
            if (k == 2) begin
              cyc(~st, 1'b1, 1'b1, 1'b1, ~lin[0]);
              chk(cur, "R7 hold");
            end
          end
          chk(st, "R6 wrap to start");
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule